// File: doc/BRIEF.md
# NAND Page ECC Segment Sequencer

This block steps through one NAND page as a stream of nibbles. For every nibble it tells a downstream ECC accumulator which per-sector syndrome buffer is in use and whether that nibble feeds the syndrome or is skipped. A page always starts with S data sectors. A spare area follows, split into three kinds of segment: one shared segment of programmable length, an optional one-nibble pad ahead of each sector's own spare segment, and S per-sector segments. The selected layout decides which of these segments are processed and which buffer each one uses.

Software, or a controller above this block, sets the layout code, the sector count and the two spare lengths, then pulses start. The NAND interface strobes `nib_vld_i` once per nibble transferred. The outputs are combinational from the walker state. They describe the nibble being strobed in the current cycle, so the accumulator can qualify its update with the same strobe.

Top module: `nand_ecc_seg_seq`

## Requirements
- R1: After an accepted start, the page begins with S data sectors, each lasting SECT_NIBBLES strobes (1024 by default). Sector k is processed into buffer k, for k = 0..S-1 in order.
- R2: Layout code 4'h7: after the data, the shared segment (share_len nibbles) is processed into buffer 0. Then S segments of sect_spare_len nibbles each are skipped with no buffer selected.
- R3: Layout code 4'h8: the shared segment is processed into buffer 0. Then, for k = 0..S-1, one pad nibble is skipped, followed by sect_spare_len nibbles processed into buffer k.
- R4: Layout code 4'h4: the shared segment is skipped with no buffer selected. Then, for k = 0..S-1, sect_spare_len nibbles are processed into buffer k.
- R5: Layout code 4'h9: the shared segment is skipped. Then, for k = 0..S-1, one skipped pad nibble is followed by sect_spare_len nibbles processed into buffer k.
- R6: A share_len or sect_spare_len of zero makes that segment empty. The walk passes through an empty segment without using a strobe.
- R7: The position advances only on a cycle with nib_vld_i high. Cycles without the strobe leave every output unchanged.
- R8: page_done_o is high for exactly one cycle, the cycle after the strobe of the last nibble. busy_o is low from that cycle on.
- R9: buf_vld_o equals proc_en_o. Whenever a nibble is skipped, or no page is active, buf_vld_o and proc_en_o are low and buf_idx_o is 0.
- R10: A start during an active page is ignored. The layout, sector count and lengths are captured at the accepted start, and later changes on those inputs have no effect on the page in progress.
- R11: A start whose layout code is not 4'h4, 4'h7, 4'h8 or 4'h9, or whose sector count is outside 1..MAX_SECT, is ignored and busy_o stays low.
- R12: seg_end_o is high exactly on the last nibble of each non-empty segment, pads included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-of-page pulse |
| mode_i | input | 4 | Layout code (4'h4, 4'h7, 4'h8, 4'h9) |
| sect_cnt_i | input | $clog2(MAX_SECT+1) | Sector count S |
| share_len_i | input | SIZE_W | Shared spare segment length in nibbles |
| sect_spare_len_i | input | SIZE_W | Per-sector spare segment length in nibbles |
| nib_vld_i | input | 1 | One nibble transferred this cycle |
| busy_o | output | 1 | Page walk in progress |
| buf_idx_o | output | max(1,$clog2(MAX_SECT)) | Syndrome buffer of the current nibble |
| proc_en_o | output | 1 | Current nibble feeds the syndrome |
| buf_vld_o | output | 1 | buf_idx_o names a buffer |
| seg_end_o | output | 1 | Current nibble closes its segment |
| page_done_o | output | 1 | One-cycle pulse after the final nibble |

## Verification
The assertions assume that start_i and nib_vld_i are never X after reset. They also assume that nib_vld_i may arrive in any cycle, including the cycle in which a start is accepted, where it is then ignored. The bench raises nib_vld_i only while a page is active and drives every input at the falling edge. The bench walks every layout code with each sector count from 1 to 4 and each spare length from 0 to 2 or 3. Along the way it inserts idle cycles, repeats start pulses and changes the configuration inputs mid-page, so that the latching and stall assumptions are exercised without being violated.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  typedef enum logic [1:0] {
    PH_DATA  = 2'd0,
    PH_SHARE = 2'd1,
    PH_PAD   = 2'd2,
    PH_PER   = 2'd3
  } seg_ph_e;

  localparam logic [3:0] LAY_SHARE_ONLY = 4'h7;
  localparam logic [3:0] LAY_BOTH_PAD   = 4'h8;
  localparam logic [3:0] LAY_PER_ONLY   = 4'h4;
  localparam logic [3:0] LAY_PER_PAD    = 4'h9;

  typedef struct packed {
    logic share_on;
    logic per_on;
    logic pad_on;
  } lay_flags_t;

  function automatic logic lay_ok(logic [3:0] m);
    return (m == LAY_SHARE_ONLY) || (m == LAY_BOTH_PAD) ||
           (m == LAY_PER_ONLY)   || (m == LAY_PER_PAD);
  endfunction

  function automatic lay_flags_t lay_decode(logic [3:0] m);
    lay_flags_t f;
    f = '0;
    case (m)
      LAY_SHARE_ONLY: f.share_on = 1'b1;
      LAY_BOTH_PAD: begin
        f.share_on = 1'b1;
        f.per_on   = 1'b1;
        f.pad_on   = 1'b1;
      end
      LAY_PER_ONLY: f.per_on = 1'b1;
      LAY_PER_PAD: begin
        f.per_on = 1'b1;
        f.pad_on = 1'b1;
      end
      default: f = '0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/nseq_cfg.sv
module nseq_cfg
  import nseq_pkg::*;
#(
  parameter int MAX_SECT = 8,
  parameter int SIZE_W   = 8,
  localparam int S_W     = $clog2(MAX_SECT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic [3:0]        mode_i,
  input  logic [S_W-1:0]    sect_cnt_i,
  input  logic [SIZE_W-1:0] share_len_i,
  input  logic [SIZE_W-1:0] sect_spare_len_i,
  output logic              accept_o,
  output lay_flags_t        flags_o,
  output logic [S_W-1:0]    sect_cnt_o,
  output logic [SIZE_W-1:0] share_len_o,
  output logic [SIZE_W-1:0] sect_spare_len_o
);

  logic cnt_ok;
  assign cnt_ok   = (sect_cnt_i != '0) && (sect_cnt_i <= S_W'(MAX_SECT));
  assign accept_o = start_i && !busy_i && lay_ok(mode_i) && cnt_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o          <= '0;
      sect_cnt_o       <= S_W'(1);
      share_len_o      <= '0;
      sect_spare_len_o <= '0;
    end else if (accept_o) begin
      flags_o          <= lay_decode(mode_i);
      sect_cnt_o       <= sect_cnt_i;
      share_len_o      <= share_len_i;
      sect_spare_len_o <= sect_spare_len_i;
    end
  end

  // config frozen while a page runs
  assert_cfg_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(flags_o) && $stable(sect_cnt_o) &&
                $stable(share_len_o) && $stable(sect_spare_len_o)));

  assert_cnt_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (sect_cnt_o != '0 && sect_cnt_o <= S_W'(MAX_SECT)));

endmodule

// File: rtl/nseq_walker.sv
module nseq_walker
  import nseq_pkg::*;
#(
  parameter int MAX_SECT     = 8,
  parameter int SECT_NIBBLES = 1024,
  parameter int SIZE_W       = 8,
  localparam int S_W         = $clog2(MAX_SECT + 1),
  localparam int NB_W        = $clog2(SECT_NIBBLES),
  localparam int CNT_W       = (NB_W > SIZE_W) ? NB_W : SIZE_W,
  localparam int LEN_W       = CNT_W + 1,
  localparam int STEPS       = 2 * MAX_SECT + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              nib_vld_i,
  input  lay_flags_t        flags_i,
  input  logic [S_W-1:0]    sect_cnt_i,
  input  logic [SIZE_W-1:0] share_len_i,
  input  logic [SIZE_W-1:0] sect_spare_len_i,
  output logic              busy_o,
  output seg_ph_e           ph_o,
  output logic [S_W-1:0]    sect_o,
  output logic              seg_last_o,
  output logic              done_o
);

  seg_ph_e          ph_q;
  logic [S_W-1:0]   k_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  function automatic logic [LEN_W-1:0] len_of(seg_ph_e p);
    case (p)
      PH_DATA:  return LEN_W'(SECT_NIBBLES);
      PH_SHARE: return LEN_W'(share_len_i);
      PH_PAD:   return flags_i.pad_on ? LEN_W'(1) : '0;
      default:  return LEN_W'(sect_spare_len_i);
    endcase
  endfunction

  logic [LEN_W-1:0] cur_len;
  assign cur_len    = len_of(ph_q);
  assign seg_last_o = busy_q && ({1'b0, cnt_q} == cur_len - 1'b1);

  // find next non-empty segment, or the end of page
  seg_ph_e        nx_ph;
  logic [S_W-1:0] nx_k;
  logic           nx_hit, nx_fin;

  always_comb begin
    nx_ph  = ph_q;
    nx_k   = k_q;
    nx_hit = 1'b0;
    nx_fin = 1'b0;
    for (int i = 0; i < STEPS; i++) begin
      if (!nx_hit && !nx_fin) begin
        case (nx_ph)
          PH_DATA: begin
            if (nx_k == sect_cnt_i - 1'b1) nx_ph = PH_SHARE;
            else                           nx_k  = nx_k + 1'b1;
          end
          PH_SHARE: begin
            nx_ph = PH_PAD;
            nx_k  = '0;
          end
          PH_PAD: nx_ph = PH_PER;
          default: begin
            if (nx_k == sect_cnt_i - 1'b1) nx_fin = 1'b1;
            else begin
              nx_ph = PH_PAD;
              nx_k  = nx_k + 1'b1;
            end
          end
        endcase
        if (!nx_fin && len_of(nx_ph) != '0) nx_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ph_q   <= PH_DATA;
      k_q    <= '0;
      cnt_q  <= '0;
    end else if (accept_i) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      ph_q   <= PH_DATA;
      k_q    <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q && nib_vld_i) begin
        if (seg_last_o) begin
          cnt_q <= '0;
          if (!nx_hit) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            ph_q   <= PH_DATA;
            k_q    <= '0;
          end else begin
            ph_q <= nx_ph;
            k_q  <= nx_k;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign ph_o   = ph_q;
  assign sect_o = k_q;
  assign done_o = done_q;

  assert_seg_nonempty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cur_len != '0 && {1'b0, cnt_q} < cur_len));

  assert_hold_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !nib_vld_i && !accept_i) |=>
      ($stable(cnt_q) && $stable(ph_q) && $stable(k_q) && busy_q));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!busy_q && $past(busy_q) && $past(nib_vld_i)));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_sect_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (k_q < sect_cnt_i));

endmodule

// File: rtl/nseq_outmap.sv
module nseq_outmap
  import nseq_pkg::*;
#(
  parameter int MAX_SECT = 8,
  localparam int S_W     = $clog2(MAX_SECT + 1),
  localparam int IDX_W   = (MAX_SECT > 1) ? $clog2(MAX_SECT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  seg_ph_e          ph_i,
  input  logic [S_W-1:0]   sect_i,
  input  logic [S_W-1:0]   sect_cnt_i,
  input  lay_flags_t       flags_i,
  output logic             proc_en_o,
  output logic             buf_vld_o,
  output logic [IDX_W-1:0] buf_idx_o
);

  logic             proc;
  logic [IDX_W-1:0] idx;

  always_comb begin
    proc = 1'b0;
    idx  = '0;
    case (ph_i)
      PH_DATA: begin
        proc = 1'b1;
        idx  = IDX_W'(sect_i);
      end
      PH_SHARE: proc = flags_i.share_on;
      PH_PAD:   proc = 1'b0;
      default: begin
        proc = flags_i.per_on;
        idx  = IDX_W'(sect_i);
      end
    endcase
  end

  assign proc_en_o = busy_i && proc;
  assign buf_vld_o = proc_en_o;
  assign buf_idx_o = proc_en_o ? idx : '0;

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!proc_en_o && !buf_vld_o && buf_idx_o == '0));

  assert_idx_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_vld_o |-> ({1'b0, buf_idx_o} < (IDX_W + 1)'(sect_cnt_i)));

  assert_pad_skip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && ph_i == PH_PAD) |-> (flags_i.pad_on && !proc_en_o));

endmodule

// File: rtl/nand_ecc_seg_seq.sv
module nand_ecc_seg_seq
  import nseq_pkg::*;
#(
  parameter int MAX_SECT     = 8,
  parameter int SECT_NIBBLES = 1024,
  parameter int SIZE_W       = 8,
  localparam int S_W         = $clog2(MAX_SECT + 1),
  localparam int IDX_W       = (MAX_SECT > 1) ? $clog2(MAX_SECT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        mode_i,
  input  logic [S_W-1:0]    sect_cnt_i,
  input  logic [SIZE_W-1:0] share_len_i,
  input  logic [SIZE_W-1:0] sect_spare_len_i,
  input  logic              nib_vld_i,
  output logic              busy_o,
  output logic [IDX_W-1:0]  buf_idx_o,
  output logic              proc_en_o,
  output logic              buf_vld_o,
  output logic              seg_end_o,
  output logic              page_done_o
);

  logic              accept;
  lay_flags_t        flags;
  logic [S_W-1:0]    s_q;
  logic [SIZE_W-1:0] sh_len_q, sp_len_q;
  seg_ph_e           ph;
  logic [S_W-1:0]    sect;
  logic              busy;

  nseq_cfg #(.MAX_SECT(MAX_SECT), .SIZE_W(SIZE_W)) u_cfg (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .start_i          (start_i),
    .busy_i           (busy),
    .mode_i           (mode_i),
    .sect_cnt_i       (sect_cnt_i),
    .share_len_i      (share_len_i),
    .sect_spare_len_i (sect_spare_len_i),
    .accept_o         (accept),
    .flags_o          (flags),
    .sect_cnt_o       (s_q),
    .share_len_o      (sh_len_q),
    .sect_spare_len_o (sp_len_q)
  );

  nseq_walker #(
    .MAX_SECT(MAX_SECT), .SECT_NIBBLES(SECT_NIBBLES), .SIZE_W(SIZE_W)
  ) u_walk (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .accept_i         (accept),
    .nib_vld_i        (nib_vld_i),
    .flags_i          (flags),
    .sect_cnt_i       (s_q),
    .share_len_i      (sh_len_q),
    .sect_spare_len_i (sp_len_q),
    .busy_o           (busy),
    .ph_o             (ph),
    .sect_o           (sect),
    .seg_last_o       (seg_end_o),
    .done_o           (page_done_o)
  );

  nseq_outmap #(.MAX_SECT(MAX_SECT)) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy),
    .ph_i       (ph),
    .sect_i     (sect),
    .sect_cnt_i (s_q),
    .flags_i    (flags),
    .proc_en_o  (proc_en_o),
    .buf_vld_o  (buf_vld_o),
    .buf_idx_o  (buf_idx_o)
  );

  assign busy_o = busy;

  assert_bad_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy && !lay_ok(mode_i)) |=> !busy);

endmodule

// File: tb/sim_nand_ecc_seg_seq.sv
module sim_nand_ecc_seg_seq;
  localparam int MS  = 4;
  localparam int SN  = 16;
  localparam int SZW = 4;
  localparam int S_W = 3;
  localparam int IW  = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n;
  logic           start_i = 1'b0;
  logic [3:0]     mode_i = 4'h0;
  logic [S_W-1:0] sect_cnt_i = '0;
  logic [SZW-1:0] share_len_i = '0;
  logic [SZW-1:0] spare_len_i = '0;
  logic           nib_vld_i = 1'b0;
  logic           busy_o, proc_en_o, buf_vld_o, seg_end_o, page_done_o;
  logic [IW-1:0]  buf_idx_o;

  nand_ecc_seg_seq #(.MAX_SECT(MS), .SECT_NIBBLES(SN), .SIZE_W(SZW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .mode_i(mode_i),
    .sect_cnt_i(sect_cnt_i), .share_len_i(share_len_i),
    .sect_spare_len_i(spare_len_i), .nib_vld_i(nib_vld_i),
    .busy_o(busy_o), .buf_idx_o(buf_idx_o), .proc_en_o(proc_en_o),
    .buf_vld_o(buf_vld_o), .seg_end_o(seg_end_o), .page_done_o(page_done_o)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit gap = 0;
  bit disturb = 0;
  int nib_n = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic look(string tag, bit p, int idx, bit last);
    chk(tag, busy_o, 1);
    chk(tag, proc_en_o, p);
    chk(p ? tag : "R9", buf_vld_o, p);
    chk(p ? tag : "R9", buf_idx_o, p ? idx : 0);
    chk("R12", seg_end_o, last);
    chk("R8", page_done_o, 0);
  endtask

  task automatic nib(string tag, bit p, int idx, bit last);
    look(tag, p, idx, last);
    nib_n++;
    if (gap && (nib_n % 7 == 3)) begin
      nib_vld_i = 1'b0;
      start_i = disturb;
      mode_i = 4'h4;
      sect_cnt_i = 3'd1;
      share_len_i = 4'd2;
      @(posedge clk); @(negedge clk);
      start_i = 1'b0;
      look(disturb ? "R10" : "R7", p, idx, last);
    end
    nib_vld_i = 1'b1;
    @(posedge clk); @(negedge clk);
    nib_vld_i = 1'b0;
  endtask

  task automatic run_page(logic [3:0] m, int s, int z0, int z1);
    bit sh_on, per_on, pad_on;
    string mt;
    sh_on  = (m == 4'h7) || (m == 4'h8);
    per_on = (m != 4'h7);
    pad_on = (m == 4'h8) || (m == 4'h9);
    mt = (m == 4'h7) ? "R2" : (m == 4'h8) ? "R3" : (m == 4'h4) ? "R4" : "R5";
    if (z0 == 0 || z1 == 0) mt = {mt, "/R6"};
    start_i = 1'b1; mode_i = m; sect_cnt_i = S_W'(s);
    share_len_i = SZW'(z0); spare_len_i = SZW'(z1);
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    mode_i = 4'h9 ^ m; sect_cnt_i = 3'd4; share_len_i = 4'd5; spare_len_i = 4'd7;
    nib_n = 0;
    for (int k = 0; k < s; k++)
      for (int n = 0; n < SN; n++) nib("R1", 1'b1, k, n == SN - 1);
    for (int n = 0; n < z0; n++) nib(mt, sh_on, 0, n == z0 - 1);
    for (int k = 0; k < s; k++) begin
      if (pad_on) nib(mt, 1'b0, 0, 1'b1);
      for (int n = 0; n < z1; n++) nib(mt, per_on, k, n == z1 - 1);
    end
    chk("R8", page_done_o, 1);
    chk("R8", busy_o, 0);
    chk("R9", buf_vld_o, 0);
    @(posedge clk); @(negedge clk);
    chk("R8", page_done_o, 0);
    chk("R8", busy_o, 0);
  endtask

  task automatic bad_start(logic [3:0] m, int s);
    start_i = 1'b1; mode_i = m; sect_cnt_i = S_W'(s);
    share_len_i = 4'd1; spare_len_i = 4'd1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    chk("R11", busy_o, 0);
    chk("R11", proc_en_o, 0);
  endtask

  initial begin
    logic [3:0] modes [4];
    modes[0] = 4'h7; modes[1] = 4'h8; modes[2] = 4'h4; modes[3] = 4'h9;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", busy_o, 0);
    chk("R9", proc_en_o, 0);
    chk("R9", buf_vld_o, 0);
    chk("R9", buf_idx_o, 0);
    chk("R8", page_done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    bad_start(4'h5, 2);
    bad_start(4'h0, 1);
    bad_start(4'h7, 0);
    bad_start(4'h8, MS + 1);
    for (int mi = 0; mi < 4; mi++)
      for (int s = 1; s <= MS; s++)
        for (int z0 = 0; z0 <= 3; z0++)
          for (int z1 = 0; z1 <= 2; z1++) begin
            gap = ((s + z0 + z1) % 2) == 1;
            disturb = (z0 == 1);
            run_page(modes[mi], s, z0, z1);
          end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule